// File: doc/BRIEF.md
# Presettable Binary Down Counter with Zero Detect

This block is a parameterised binary down counter (8 bits by default) that steps down by one on every rising clock edge while its count enable is active. A parallel jam word can be loaded into it either on the next clock edge or at once, without waiting for an edge. The count can also be forced to all-ones at once. Every control input is active low.

The zero-detect output is active low. It is asserted while the count is zero and the count enable is active. Because of this qualification, the zero-detect of one instance can drive the count enable of the next instance on a common clock, and the chained instances then count as one wider down counter. The four controls have a fixed order of precedence:

1. clear
2. immediate load
3. edge load
4. count enable

The block has no data stream, so it has no valid/ready handshake: every pin is a plain level.

Top module: `presettable_down_counter`

## Requirements
- R1: While `clr_n` is 0, `count` reads all-ones (255 at the default width) at once, whatever the other inputs do.
- R2: While `clr_n` is 1 and `apre_n` is 0, `count` follows `jam` at once, with no clock edge needed, whatever `spre_n` and `cnt_en_n` are. After `apre_n` returns to 1, the count holds the last jam value captured.
- R3: With `clr_n` and `apre_n` at 1 and `spre_n` at 0, `jam` is loaded at the next rising edge, even when `cnt_en_n` is 1.
- R4: With `clr_n`, `apre_n` and `spre_n` at 1 and `cnt_en_n` at 1, the count holds across rising edges.
- R5: With `clr_n`, `apre_n` and `spre_n` at 1 and `cnt_en_n` at 0, the count decreases by exactly one at each rising edge.
- R6: A decrement from zero gives all-ones, so free-running counting repeats every 256 edges.
- R7: `zero_n` is 0 exactly when `count` is zero and `cnt_en_n` is 0. It is combinational, with no clock delay.
- R8: Two instances on one clock, where the low instance has its enable tied to 0 and its `zero_n` drives the high instance's `cnt_en_n`, step through a 16-bit down sequence {high, low}. The high instance's `zero_n` is 0 only when the full 16-bit value is zero.
- R9: When `clr_n` and `apre_n` are both 0, clear wins and `count` reads all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Counting and edge loads happen on the rising edge. |
| clr_n | input | 1 | Asynchronous clear to all-ones, active low. |
| apre_n | input | 1 | Asynchronous (immediate) jam load, active low. |
| spre_n | input | 1 | Synchronous (edge) jam load, active low. |
| cnt_en_n | input | 1 | Count enable / carry in, active low. |
| jam | input | WIDTH | Parallel preset word. |
| count | output | WIDTH | Current count. |
| zero_n | output | 1 | Zero detect qualified by count enable (carry out), active low. |

## Verification
The results arrive with three different delays, and the bench samples each one accordingly:

- Clear and immediate load take effect with zero cycles of delay. The bench applies them in the middle of a clock low phase and checks `count` 1 ns later, before any edge can interfere.
- Edge loads, decrements and holds take effect at the first rising edge after the inputs are driven. The bench drives inputs on the falling edge and compares at the next falling edge, so exactly one register stage lies between stimulus and check.
- Zero detect is combinational. It is compared at the same instant as the count it depends on, both against a behavioural model that follows the precedence order at every edge.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } edge_act_e;
endpackage

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
(
  input  logic      spre_n,
  input  logic      cnt_en_n,
  output edge_act_e act_o
);
  // Edge-time precedence: a synchronous load beats the count enable.
  always_comb begin
    if (!spre_n)        act_o = ACT_LOAD;
    else if (!cnt_en_n) act_o = ACT_DEC;
    else                act_o = ACT_HOLD;
  end
endmodule

// File: rtl/dcnt_reg.sv
module dcnt_reg
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             apre_n,
  input  edge_act_e        act_i,
  input  logic [WIDTH-1:0] jam_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;
  localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge clr_n or negedge apre_n) begin
    if (!clr_n)       cnt_q <= CNT_MAX;
    else if (!apre_n) cnt_q <= jam_i;
    else begin
      unique case (act_i)
        ACT_LOAD: cnt_q <= jam_i;
        ACT_DEC:  cnt_q <= cnt_q - CNT_ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // Visible count: asynchronous controls act at once; jam is tracked while held.
  assign cnt_o = !clr_n ? CNT_MAX : (!apre_n ? jam_i : cnt_q);

  p_edge_load_r3: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
    (act_i == ACT_LOAD) |=> (cnt_q == $past(jam_i)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
    (act_i == ACT_HOLD) |=> $stable(cnt_q));

  p_step_r5: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
    (act_i == ACT_DEC) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n || !apre_n)
    (act_i == ACT_DEC && cnt_q == '0) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/dcnt_zero.sv
module dcnt_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             cnt_en_n,
  output logic             zero_n
);
  assign zero_n = ~((cnt_i == '0) & ~cnt_en_n);
endmodule

// File: rtl/presettable_down_counter.sv
module presettable_down_counter
  import dcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             apre_n,
  input  logic             spre_n,
  input  logic             cnt_en_n,
  input  logic [WIDTH-1:0] jam,
  output logic [WIDTH-1:0] count,
  output logic             zero_n
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  edge_act_e act;

  dcnt_ctrl u_ctrl (
    .spre_n   (spre_n),
    .cnt_en_n (cnt_en_n),
    .act_o    (act)
  );

  dcnt_reg #(.WIDTH(WIDTH)) u_reg (
    .clk    (clk),
    .clr_n  (clr_n),
    .apre_n (apre_n),
    .act_i  (act),
    .jam_i  (jam),
    .cnt_o  (count)
  );

  dcnt_zero #(.WIDTH(WIDTH)) u_zero (
    .cnt_i    (count),
    .cnt_en_n (cnt_en_n),
    .zero_n   (zero_n)
  );

  // R1 and R9: clear dominates every other control.
  always @(posedge clk) begin
    if (!clr_n) begin
      p_clear_max_r1: assert (count == CNT_MAX);
    end
  end

  p_zero_qual_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (!zero_n) |-> (count == '0 && !cnt_en_n));

  p_zero_seen_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (count == '0 && !cnt_en_n) |-> !zero_n);
endmodule

// File: tb/presettable_down_counter_test.sv
module presettable_down_counter_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic clr_n = 1'b0, apre_n = 1'b1, spre_n = 1'b1, cnt_en_n = 1'b1;
  logic [W-1:0] jam = '0;
  logic [W-1:0] count;
  logic zero_n;

  presettable_down_counter #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .apre_n(apre_n), .spre_n(spre_n),
    .cnt_en_n(cnt_en_n), .jam(jam), .count(count), .zero_n(zero_n)
  );

  // Two-stage cascade on the common clock (R8).
  logic cclr_n = 1'b0;
  logic [W-1:0] lo_q, hi_q;
  logic lo_z, hi_z;

  presettable_down_counter #(.WIDTH(W)) u_lo (
    .clk(clk), .clr_n(cclr_n), .apre_n(1'b1), .spre_n(1'b1),
    .cnt_en_n(1'b0), .jam('0), .count(lo_q), .zero_n(lo_z)
  );
  presettable_down_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .clr_n(cclr_n), .apre_n(1'b1), .spre_n(1'b1),
    .cnt_en_n(lo_z), .jam('0), .count(hi_q), .zero_n(hi_z)
  );

  int n_chk = 0, n_fail = 0;

  // Behavioural reference of the precedence table.
  int m = 255;
  always @(posedge clk or negedge clr_n or negedge apre_n) begin
    if (!clr_n)         m = 255;
    else if (!apre_n)   m = int'(jam);
    else if (!spre_n)   m = int'(jam);
    else if (!cnt_en_n) m = (m + 255) % 256;
  end

  int c16 = 65535;
  always @(posedge clk) begin
    if (!cclr_n) c16 = 65535;
    else         c16 = (c16 + 65535) % 65536;
  end

  function automatic int exp_count();
    if (!clr_n)  return 255;
    if (!apre_n) return int'(jam);
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sample(input string tag);
    int e, ez;
    e  = exp_count();
    ez = (e == 0 && !cnt_en_n) ? 0 : 1;
    chk(int'(count) == e, tag, int'(count), e);
    chk(int'(zero_n) == ez, "R7 zero detect", int'(zero_n), ez);
  endtask

  task automatic tick(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample(tag);
    end
  endtask

  bit done = 1'b0;

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: clear holds all-ones, even with enable and edge load active.
    tick(2, "R1 clear");
    cnt_en_n = 1'b0; spre_n = 1'b0; jam = 8'h5A;
    tick(2, "R1 clear beats other controls");
    @(negedge clk);
    spre_n = 1'b1; clr_n = 1'b1;
    // R5 and R6: free-running count through the zero-to-max wrap.
    tick(300, "R5 R6 decrement and wrap");
    // R4: hold.
    cnt_en_n = 1'b1;
    tick(5, "R4 hold");
    // R3: edge load while count enable is inactive.
    spre_n = 1'b0; jam = 8'h3C;
    tick(1, "R3 edge load with enable high");
    spre_n = 1'b1; cnt_en_n = 1'b0;
    tick(3, "R5 decrement after load");
    // R3 then R7: load zero, then see zero detect gated by the enable.
    spre_n = 1'b0; jam = 8'h00;
    tick(1, "R3 edge load zero");
    spre_n = 1'b1; cnt_en_n = 1'b1;
    tick(1, "R7 zero with enable inactive");
    cnt_en_n = 1'b0;
    tick(2, "R6 wrap after zero");
    // R2: immediate load overrides edge load and the clock.
    spre_n = 1'b0; jam = 8'h81;
    #2 apre_n = 1'b0;
    #1 sample("R2 immediate load");
    tick(1, "R2 held across edge");
    jam = 8'h42;
    #1 sample("R2 tracks jam");
    tick(1, "R2 tracks jam across edge");
    apre_n = 1'b1; spre_n = 1'b1;
    #1 sample("R2 value kept after release");
    tick(3, "R5 decrement after release");
    // R9: clear while immediate load is held.
    apre_n = 1'b0; jam = 8'h10;
    #1 sample("R2 immediate load");
    #1 clr_n = 1'b0;
    #1 sample("R9 clear beats immediate load");
    tick(1, "R9 clear beats immediate load");
    clr_n = 1'b1;
    #1 sample("R2 immediate load after clear release");
    tick(1, "R2 immediate load");
    apre_n = 1'b1;
    tick(2, "R5 decrement");
    // R8: 16-bit cascade through a full period and its zero.
    @(negedge clk);
    cclr_n = 1'b1;
    for (int i = 0; i < 65600; i++) begin
      @(negedge clk);
      chk(int'({hi_q, lo_q}) == c16, "R8 cascade value", int'({hi_q, lo_q}), c16);
      chk(int'(hi_z) == ((c16 == 0) ? 0 : 1), "R8 cascade zero", int'(hi_z),
          (c16 == 0) ? 0 : 1);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule